// File: doc/BRIEF.md
# Reset Cause Controller

This block gathers every reason the chip may need to restart. The sources are power-up, the bidirectional reset pad, a watchdog expiry, an undefined opcode, an opcode fetched from an unmapped address, a mode-change request and a low-supply warning. From these it produces one internal reset. While the internal reset is held, the block pulls the reset pad low. Once it releases the pad, it waits a fixed delay and then samples the pad again. A pad that is still low at that sample counts as an external reset.

For each cause it also sets a bit in a read-only cause register. Bits from different causes accumulate until software reads the register. That read returns the current value and then empties the register, so boot code can tell why the chip restarted.

Top module: `reset_cause_unit`

## Requirements
- R1: While and right after `por_n` is low, `stat_rdata` reads 0x80 and both `sys_rst` and `rst_pin_pull` are 1.
- R2: `opc_dec_stb` together with `opc_undefined` starts a reset and sets bit 4. `opc_dec_stb` alone has no effect.
- R3: `stop_stb` with `stop_enable` = 0 starts a reset and sets bit 4. With `stop_enable` = 1 it has no effect.
- R4: `bus_fetch_stb` with `bus_opcode_fetch` = 1 and `bus_addr_mapped` = 0 starts a reset and sets bit 3. The same access with `bus_opcode_fetch` = 0 has no effect.
- R5: `wdt_timeout`, `mode_rst_req` and `lowv_req` each start a reset and set bit 5, bit 2 and bit 1 respectively.
- R6: `stat_rdata` shows the cause bits with bit 0 always 0. A clock edge with `stat_rd` high clears every bit.
- R7: Without a read, bits from several causes stay set together.
- R8: When a read lands on the same edge as a new cause bit is set, that new bit survives and all older bits clear.
- R9: After the last cause, `rst_pin_pull` stays high for 64 cycles. `sys_rst` then stays high for another 32 cycles.
- R10: On the 32nd cycle after the pad is released, the synchronized pad level is sampled. If it is low, bit 6 is set and a new 64-cycle hold begins. If it is high, `sys_rst` falls.
- R11: With the block running, a low pad level passes a two-flop synchronizer. The third edge after that starts a reset and sets bit 6.
- R12: A source request is registered once. It shows in `stat_rdata` and `sys_rst` after the second rising edge from when it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_in | input | 1 | Level seen on the reset pad |
| opc_dec_stb | input | 1 | Opcode decoded this cycle |
| opc_undefined | input | 1 | Decoded opcode is outside the instruction set |
| stop_stb | input | 1 | STOP instruction executed |
| stop_enable | input | 1 | Option bit allowing STOP |
| bus_fetch_stb | input | 1 | Bus access this cycle |
| bus_opcode_fetch | input | 1 | Access is an opcode fetch (1) or a data fetch (0) |
| bus_addr_mapped | input | 1 | Access address is mapped |
| wdt_timeout | input | 1 | Watchdog expired |
| mode_rst_req | input | 1 | Mode-change reset request |
| lowv_req | input | 1 | Low-supply reset request |
| stat_rd | input | 1 | Cause register read strobe |
| stat_rdata | output | 8 | Cause register value |
| sys_rst | output | 1 | Internal reset |
| rst_pin_pull | output | 1 | Pull reset pad low |

## Verification
The bench builds the block with its defaults: a 64-cycle hold, a 32-cycle sample delay and a two-stage synchronizer. With these short values, full hold and sample windows can be counted cycle by cycle. Pad pulses can also be placed before and after the sample point, a few cycles away from it. A model of the cause bits tracks several hundred random cycles that mix overlapping sources with reads.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   localparam int FLAG_W   = 8;
   localparam int B_POR    = 7;
   localparam int B_PIN    = 6;
   localparam int B_WDT    = 5;
   localparam int B_BADOP  = 4;
   localparam int B_BADADR = 3;
   localparam int B_MODE   = 2;
   localparam int B_LOWV   = 1;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HOLD = 2'd1,
      ST_WAIT = 2'd2
   } seq_st_e;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rsc_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_st
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh[0] <= 1'b0;
               else        sh[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= sh[i-1];
         end
      end
   endgenerate

   assign q = sh[STAGES-1];
endmodule

// File: rtl/rsc_capture.sv
module rsc_capture
   import rsc_pkg::*;
#(
   parameter bit SRC_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              opc_stb,
   input  logic              opc_bad,
   input  logic              stop_stb,
   input  logic              stop_allow,
   input  logic              bus_stb,
   input  logic              bus_opc,
   input  logic              bus_mapped,
   input  logic              wdt_req,
   input  logic              mode_req,
   input  logic              lowv_req,
   output logic [FLAG_W-1:1] src_q
);
   logic [FLAG_W-1:1] ev_d;

   always_comb begin
      ev_d            = '0;
      ev_d[B_BADOP]   = (opc_stb & opc_bad) | (stop_stb & ~stop_allow);
      ev_d[B_BADADR]  = bus_stb & bus_opc & ~bus_mapped;
      ev_d[B_WDT]     = wdt_req;
      ev_d[B_MODE]    = mode_req;
      ev_d[B_LOWV]    = lowv_req;
   end

   generate
      if (SRC_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) src_q <= '0;
            else        src_q <= ev_d;
      end else begin : g_pass
         assign src_q = ev_d;
      end
   endgenerate
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
   import rsc_pkg::*;
#(
   parameter int STRETCH_CYC = 64,
   parameter int SAMPLE_DLY  = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_any,
   input  logic pin_s,
   output logic pin_hit,
   output logic sys_rst,
   output logic pull_low
);
   localparam int MAXC = (STRETCH_CYC > SAMPLE_DLY) ? STRETCH_CYC : SAMPLE_DLY;
   localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
   localparam logic [CW-1:0] HOLD_LAST = CW'(STRETCH_CYC - 1);
   localparam logic [CW-1:0] WAIT_LAST = CW'(SAMPLE_DLY - 1);

   seq_st_e        st, st_n;
   logic [CW-1:0]  cnt, cnt_n;

   always_comb begin
      st_n    = st;
      cnt_n   = cnt + 1'b1;
      pin_hit = 1'b0;
      unique case (st)
         ST_RUN: begin
            cnt_n = '0;
            if (!pin_s) begin
               pin_hit = 1'b1;
               st_n    = ST_HOLD;
            end
         end
         ST_HOLD: begin
            if (cnt == HOLD_LAST) begin
               st_n  = ST_WAIT;
               cnt_n = '0;
            end
         end
         ST_WAIT: begin
            if (cnt == WAIT_LAST) begin
               cnt_n = '0;
               if (!pin_s) begin
                  pin_hit = 1'b1;
                  st_n    = ST_HOLD;
               end else begin
                  st_n = ST_RUN;
               end
            end
         end
         default: begin
            st_n  = ST_RUN;
            cnt_n = '0;
         end
      endcase
      if (src_any) begin
         st_n  = ST_HOLD;
         cnt_n = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st  <= ST_HOLD;
         cnt <= '0;
      end else begin
         st  <= st_n;
         cnt <= cnt_n;
      end

   assign sys_rst  = (st != ST_RUN);
   assign pull_low = (st == ST_HOLD);

   AST_EVENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      src_any |=> (pull_low && cnt == '0)); // R9

   AST_RST_OUTLASTS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pull_low) && !$past(src_any)) |-> sys_rst); // R9

   AST_PIN_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      pin_hit |=> pull_low); // R10
endmodule

// File: rtl/rsc_flags.sv
module rsc_flags
   import rsc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [FLAG_W-1:1] set_vec,
   output logic [FLAG_W-1:0] flags
);
   localparam logic [FLAG_W-1:1] INIT = (FLAG_W-1)'(1) << (B_POR - 1);

   logic [FLAG_W-1:1] q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q <= INIT;
      else        q <= (rd ? '0 : q) | set_vec;

   assign flags = {q, 1'b0};

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && set_vec == '0) |=> (q == '0)); // R6

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> ((q & $past(q)) == $past(q))); // R7

   AST_NEW_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((q & $past(set_vec)) == $past(set_vec))); // R8
endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
   import rsc_pkg::*;
#(
   parameter int STRETCH_CYC = 64,
   parameter int SAMPLE_DLY  = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_pin_in,
   input  logic       opc_dec_stb,
   input  logic       opc_undefined,
   input  logic       stop_stb,
   input  logic       stop_enable,
   input  logic       bus_fetch_stb,
   input  logic       bus_opcode_fetch,
   input  logic       bus_addr_mapped,
   input  logic       wdt_timeout,
   input  logic       mode_rst_req,
   input  logic       lowv_req,
   input  logic       stat_rd,
   output logic [7:0] stat_rdata,
   output logic       sys_rst,
   output logic       rst_pin_pull
);
   generate
      if (STRETCH_CYC < 2) begin : g_chk_hold
         $error("STRETCH_CYC must be at least 2");
      end
      if (SAMPLE_DLY < 2) begin : g_chk_wait
         $error("SAMPLE_DLY must be at least 2");
      end
   endgenerate

   logic [FLAG_W-1:1] src_q;
   logic [FLAG_W-1:1] set_vec;
   logic              pin_s;
   logic              pin_hit;
   logic              src_any;

   rsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (por_n), .d (rst_pin_in), .q (pin_s)
   );

   rsc_capture #(.SRC_REG(1'b1)) u_cap (
      .clk        (clk),
      .rst_n      (por_n),
      .opc_stb    (opc_dec_stb),
      .opc_bad    (opc_undefined),
      .stop_stb   (stop_stb),
      .stop_allow (stop_enable),
      .bus_stb    (bus_fetch_stb),
      .bus_opc    (bus_opcode_fetch),
      .bus_mapped (bus_addr_mapped),
      .wdt_req    (wdt_timeout),
      .mode_req   (mode_rst_req),
      .lowv_req   (lowv_req),
      .src_q      (src_q)
   );

   assign src_any = |src_q;

   rsc_seq #(.STRETCH_CYC(STRETCH_CYC), .SAMPLE_DLY(SAMPLE_DLY)) u_seq (
      .clk      (clk),
      .rst_n    (por_n),
      .src_any  (src_any),
      .pin_s    (pin_s),
      .pin_hit  (pin_hit),
      .sys_rst  (sys_rst),
      .pull_low (rst_pin_pull)
   );

   always_comb begin
      set_vec        = src_q;
      set_vec[B_PIN] = src_q[B_PIN] | pin_hit;
   end

   rsc_flags u_flags (
      .clk     (clk),
      .rst_n   (por_n),
      .rd      (stat_rd),
      .set_vec (set_vec),
      .flags   (stat_rdata)
   );

   AST_SRC_RESETS: assert property (@(posedge clk) disable iff (!por_n)
      src_any |=> sys_rst); // R5

   AST_DATA_FETCH_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      (bus_fetch_stb && !bus_opcode_fetch && !opc_dec_stb && !stop_stb && !wdt_timeout
       && !mode_rst_req && !lowv_req) |=> !src_any); // R4
endmodule

// File: tb/reset_cause_unit_tb.sv
module reset_cause_unit_tb;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic ext_n = 1'b1;
   logic opc_dec_stb = 0, opc_undefined = 0, stop_stb = 0, stop_enable = 1;
   logic bus_fetch_stb = 0, bus_opcode_fetch = 0, bus_addr_mapped = 1;
   logic wdt_timeout = 0, mode_rst_req = 0, lowv_req = 0, stat_rd = 0;
   logic [7:0] stat_rdata;
   logic sys_rst, rst_pin_pull, pad;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [7:0] m_flags = 8'h80, m_evq = 8'h00;

   assign pad = rst_pin_pull ? 1'b0 : ext_n;

   always #(CLK_P/2) clk = ~clk;

   reset_cause_unit u_dut (
      .clk (clk), .por_n (por_n), .rst_pin_in (pad),
      .opc_dec_stb (opc_dec_stb), .opc_undefined (opc_undefined),
      .stop_stb (stop_stb), .stop_enable (stop_enable),
      .bus_fetch_stb (bus_fetch_stb), .bus_opcode_fetch (bus_opcode_fetch),
      .bus_addr_mapped (bus_addr_mapped), .wdt_timeout (wdt_timeout),
      .mode_rst_req (mode_rst_req), .lowv_req (lowv_req), .stat_rd (stat_rd),
      .stat_rdata (stat_rdata), .sys_rst (sys_rst), .rst_pin_pull (rst_pin_pull)
   );

   function automatic logic [7:0] ev_now();
      logic [7:0] e = 8'h00;
      e[4] = (opc_dec_stb & opc_undefined) | (stop_stb & ~stop_enable);
      e[3] = bus_fetch_stb & bus_opcode_fetch & ~bus_addr_mapped;
      e[5] = wdt_timeout;
      e[2] = mode_rst_req;
      e[1] = lowv_req;
      return e;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      m_flags = (stat_rd ? 8'h00 : m_flags) | m_evq;
      m_evq   = ev_now();
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic quiet();
      opc_dec_stb = 0; opc_undefined = 0; stop_stb = 0;
      bus_fetch_stb = 0; bus_opcode_fetch = 0; bus_addr_mapped = 1;
      wdt_timeout = 0; mode_rst_req = 0; lowv_req = 0; stat_rd = 0;
   endtask

   task automatic do_read(output logic [7:0] v);
      stat_rd = 1;
      v = stat_rdata;
      tick();
      stat_rd = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 1000 && sys_rst; i++) tick();
   endtask

   task automatic count_while_pull(output int n);
      n = 0;
      while (rst_pin_pull && n < 1000) begin tick(); n++; end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R9 watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      void'($urandom(32'd20240611));
      quiet();
      @(negedge clk); @(negedge clk);
      chk(stat_rdata, 8'h80, "R1 cause reg during por");
      chk(rst_pin_pull, 1, "R1 pull during por");
      por_n = 1'b1;
      m_flags = 8'h80; m_evq = 8'h00;
      chk(sys_rst, 1, "R1 sys_rst after por");

      count_while_pull(n);
      chk(n, 64, "R9 pad hold after por");
      n = 0;
      while (sys_rst && n < 1000) begin tick(); n++; end
      chk(n, 32, "R9 sample wait after por");
      do_read(v);
      chk(v, 8'h80, "R6 first read");
      chk(stat_rdata, 8'h00, "R6 cleared after read");

      // legal opcode then undefined opcode
      opc_dec_stb = 1; tick(); quiet(); ticks(3);
      chk(sys_rst, 0, "R2 legal opcode ignored");
      opc_dec_stb = 1; opc_undefined = 1; tick(); quiet();
      chk(sys_rst, 0, "R12 no reset after one edge");
      chk(stat_rdata, 8'h00, "R12 no flag after one edge");
      tick();
      chk(sys_rst, 1, "R12 reset after second edge");
      chk(stat_rdata, 8'h10, "R2 undefined opcode flag");
      count_while_pull(n);
      chk(n, 64, "R9 pad hold after event");
      wait_idle(); do_read(v);
      chk(v, 8'h10, "R2 read back");

      // STOP allowed, then not allowed
      stop_enable = 1; stop_stb = 1; tick(); quiet(); ticks(3);
      chk(sys_rst, 0, "R3 allowed stop ignored");
      chk(stat_rdata, 8'h00, "R3 allowed stop no flag");
      stop_enable = 0; stop_stb = 1; tick(); quiet(); tick();
      chk(sys_rst, 1, "R3 forbidden stop resets");
      chk(stat_rdata, 8'h10, "R3 forbidden stop flag");
      stop_enable = 1;
      wait_idle(); do_read(v);

      // unmapped data fetch, then unmapped opcode fetch
      bus_fetch_stb = 1; bus_opcode_fetch = 0; bus_addr_mapped = 0; tick(); quiet(); ticks(3);
      chk(sys_rst, 0, "R4 data fetch ignored");
      chk(stat_rdata, 8'h00, "R4 data fetch no flag");
      bus_fetch_stb = 1; bus_opcode_fetch = 1; bus_addr_mapped = 0; tick(); quiet(); tick();
      chk(sys_rst, 1, "R4 opcode fetch resets");
      chk(stat_rdata, 8'h08, "R4 opcode fetch flag");
      wait_idle(); do_read(v);

      // accumulating sources
      wdt_timeout = 1; tick(); quiet(); tick();
      chk(stat_rdata, 8'h20, "R5 watchdog flag");
      chk(sys_rst, 1, "R5 watchdog resets");
      lowv_req = 1; tick(); quiet(); tick();
      chk(stat_rdata, 8'h22, "R7 watchdog plus low supply");
      mode_rst_req = 1; tick(); quiet(); tick();
      chk(stat_rdata, 8'h26, "R5 mode flag accumulates");
      wait_idle(); do_read(v);
      chk(v, 8'h26, "R7 sticky read back");
      chk(stat_rdata, 8'h00, "R6 all cleared");

      // read on the same edge as a new flag
      wdt_timeout = 1; tick(); quiet(); wait_idle();
      lowv_req = 1; tick(); quiet();
      stat_rd = 1; v = stat_rdata; tick(); stat_rd = 0;
      chk(v, 8'h20, "R8 read value before collision");
      chk(stat_rdata, 8'h02, "R8 new flag survives read");
      wait_idle(); do_read(v);

      // random phase against model
      for (int c = 0; c < 400; c++) begin
         stat_rd          = ($urandom % 4) == 0;
         opc_dec_stb      = ($urandom % 8) == 0;
         opc_undefined    = ($urandom % 2) == 0;
         stop_stb         = ($urandom % 16) == 0;
         stop_enable      = ($urandom % 2) == 0;
         bus_fetch_stb    = ($urandom % 4) == 0;
         bus_opcode_fetch = ($urandom % 2) == 0;
         bus_addr_mapped  = ($urandom % 4) != 0;
         wdt_timeout      = ($urandom % 32) == 0;
         mode_rst_req     = ($urandom % 32) == 0;
         lowv_req         = ($urandom % 32) == 0;
         tick();
         chk(stat_rdata, m_flags, "R6 R7 R8 random cause reg");
      end
      quiet(); stop_enable = 1; tick(); tick();
      wait_idle(); do_read(v);

      // external pad driven low while running
      ext_n = 0; ticks(2);
      chk(sys_rst, 0, "R11 not yet through synchronizer");
      tick();
      chk(sys_rst, 1, "R11 pad low resets");
      chk(stat_rdata, 8'h40, "R11 pad flag");
      ticks(5); ext_n = 1;
      wait_idle(); do_read(v);
      chk(v, 8'h40, "R11 read back");

      // pad still low at the sample point
      wdt_timeout = 1; tick(); quiet(); tick();
      ext_n = 0;
      count_while_pull(n);
      ticks(31);
      chk(rst_pin_pull, 0, "R10 pad released before sample");
      chk(sys_rst, 1, "R10 reset held before sample");
      tick();
      chk(rst_pin_pull, 1, "R10 low sample restarts hold");
      ext_n = 1;
      wait_idle(); do_read(v);
      chk(v, 8'h60, "R10 pad flag after low sample");

      // pad released before the sample point
      wdt_timeout = 1; tick(); quiet(); tick();
      ext_n = 0;
      count_while_pull(n);
      ticks(10); ext_n = 1; ticks(21);
      chk(sys_rst, 1, "R10 reset held until sample");
      tick();
      chk(sys_rst, 0, "R10 high sample ends reset");
      chk(rst_pin_pull, 0, "R10 no new hold");
      do_read(v);
      chk(v, 8'h20, "R10 no pad flag");

      done = 1;
      summary();
      $finish;
   end
endmodule